// File: doc/BRIEF.md
# Width-Packing Card Data Buffer Pair

This block sits between a processor or DMA engine and the serial side of a memory-card host. It holds two circular byte buffers, one per direction, of 32 bytes each by default. The processor reaches each buffer through a single data port and can move 1, 2 or 4 bytes per access. Bytes are packed and unpacked so that the earliest byte in the stream always sits in the most significant byte lane of the access width.

On the card side, each direction is a valid/ready byte stream that moves at most one byte per clock. A pulse on `xfer_start` loads a down-counter with block count times block length and empties both buffers. The counter falls by one for every byte that crosses the card side. Service requests tell the processor or DMA when to feed or drain the buffers. When the count runs out, a data-done pulse fires, with a programming-done pulse beside it for card writes.

A partial-flush pulse empties the transmit buffer and moves it onto the other half of a double-sized store, so a short final chunk can be staged in fresh space.

Top module: `mmc_byte_fifo_pair`

## Requirements
- R1: After a synchronous reset, `tx_req`, `rx_req`, `xfer_active`, `data_done`, `prog_done`, `tx_card_valid` and `rx_card_ready` are all 0, and both buffers are empty.
- R2: A `xfer_start` pulse loads the remaining-byte count with `blk_cnt` × `blk_len`, empties both buffers, sets `xfer_active` and latches the direction from `xfer_to_card` (1 = toward the card). If the product is zero, `data_done` pulses in the cycle after the start is registered and `xfer_active` then falls.
- R3: A `tx_wr_en` access pushes N bytes, where size code 0 gives N=1, code 1 gives N=2, and code 2 or 3 gives N=4. The first byte pushed is `tx_wdata` lane N-1 (bits 8N-1:8N-8), and the rest follow in descending lane order. The card receives them in that order.
- R4: A transmit push stops once the buffer holds DEPTH bytes. Bytes beyond that are discarded and never reach the card.
- R5: In card-write mode, one byte per clock goes out on `tx_card_*` while the remaining count and the buffer level are both nonzero. When either is zero nothing is offered, and nothing is ever offered in card-read mode.
- R6: `tx_req` is set on each cycle in which a card-write transfer is active with a nonzero remaining count. A `tx_wr_en` access clears it in the following cycle.
- R7: In card-read mode, a byte is accepted while the remaining count is nonzero and the receive buffer holds fewer than DEPTH bytes. Each accepted byte sets `rx_req`. An `rx_rd_en` access clears `rx_req` unless a byte is accepted in the same cycle.
- R8: An `rx_rd_en` access of N bytes (same size code as R3) pops up to N bytes. The first byte popped lands in lane N-1 of `rx_rdata`. Lanes with no data and lanes at or above N read 0. `rx_rdata` is registered and shows the result in the cycle after the access.
- R9: When the remaining count reaches zero during an active transfer, `xfer_active` falls and `data_done` is a one-cycle pulse. `prog_done` pulses together with it in card-write mode only.
- R10: A `part_flush` pulse empties the transmit buffer and switches it to the other half of its store. Bytes written before the pulse are never sent.
- R11: Receive indices wrap modulo DEPTH. A stream longer than DEPTH comes out in order across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start pulse: load count, empty buffers |
| xfer_to_card | input | 1 | Direction latched at start, 1 = write to card |
| blk_len | input | BLKLEN_W | Bytes per block |
| blk_cnt | input | NBLK_W | Number of blocks |
| tx_wr_en | input | 1 | Transmit data port write strobe |
| tx_size | input | 2 | Transmit access size code |
| tx_wdata | input | 32 | Transmit write data |
| part_flush | input | 1 | Empty transmit buffer and switch halves |
| rx_rd_en | input | 1 | Receive data port read strobe |
| rx_size | input | 2 | Receive access size code |
| rx_rdata | output | 32 | Registered receive read data |
| tx_card_data | output | 8 | Byte toward the card |
| tx_card_valid | output | 1 | Byte toward the card is valid |
| tx_card_ready | input | 1 | Card side takes the byte |
| rx_card_data | input | 8 | Byte from the card |
| rx_card_valid | input | 1 | Byte from the card is valid |
| rx_card_ready | output | 1 | Block accepts the byte |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| data_done | output | 1 | Transfer finished pulse |
| prog_done | output | 1 | Card-write finished pulse |
| xfer_active | output | 1 | Transfer in progress |

## Verification
The assertions assume that `part_flush` and `xfer_start` never coincide with a data port access. They also assume that `tx_card_ready` and `rx_card_valid` are free-running handshake inputs, and that a stalled transmit byte may vanish only when a flush or a restart clears it. The stimulus drives every input 2 ns after a rising edge, issues one control pulse at a time, and never reads or writes a data port in the same cycle as a start or a flush. The card-side source holds each receive byte until it is accepted.

// File: rtl/mmcf_pkg.sv
package mmcf_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;

  typedef enum logic [1:0] {
    ACC_ONE  = 2'd0,
    ACC_TWO  = 2'd1,
    ACC_FOUR = 2'd2,
    ACC_WIDE = 2'd3
  } acc_size_e;

  // Number of bytes moved by an access of the given size code
  function automatic logic [2:0] acc_bytes(input logic [1:0] code);
    case (acc_size_e'(code))
      ACC_ONE: return 3'd1;
      ACC_TWO: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/mmcf_tx_buf.sv
module mmcf_tx_buf
  import mmcf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              flip,
  input  logic              push_en,
  input  logic [2:0]        push_n,
  input  logic [BUS_W-1:0]  push_data,
  input  logic              pop,
  output logic [7:0]        head,
  output logic [LVL_W-1:0]  level
);
  // Double-sized store: the half bit selects the live half
  logic [7:0]       mem [2*DEPTH];
  logic             half;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] room;
  logic [2:0]       n_acc;
  logic [7:0]       lane_byte [BUS_BYTES];

  always_comb begin
    room  = LVL_W'(DEPTH) - level;
    n_acc = 3'd0;
    if (push_en)
      n_acc = (LVL_W'(push_n) > room) ? room[2:0] : push_n;
  end

  // Byte k of the push comes from lane push_n-1-k
  generate
    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      logic [1:0] src_lane;
      always_comb begin
        src_lane     = 2'(push_n - 3'd1 - 3'(k));
        lane_byte[k] = push_data[8*src_lane +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!clr && !flip) begin
      for (int k = 0; k < BUS_BYTES; k++) begin
        if (3'(k) < n_acc)
          mem[{half, wr_ptr + PTR_W'(k)}] <= lane_byte[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half   <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flip) begin
      half   <= ~half;
      wr_ptr <= rd_ptr;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= rd_ptr;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(n_acc);
      rd_ptr <= rd_ptr + PTR_W'(pop);
      level  <= level + LVL_W'(n_acc) - LVL_W'(pop);
    end
  end

  assign head = mem[{half, rd_ptr}];
endmodule

// File: rtl/mmcf_rx_buf.sv
module mmcf_rx_buf
  import mmcf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [7:0]        push_byte,
  input  logic              pop_en,
  input  logic [2:0]        pop_n,
  output logic [BUS_W-1:0]  rdata,
  output logic [LVL_W-1:0]  level
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [2:0]       n_take;
  logic [2:0]       idx;
  logic [7:0]       lane_val [BUS_BYTES];
  logic [BUS_W-1:0] packed_val;

  always_comb begin
    n_take = 3'd0;
    if (pop_en)
      n_take = (LVL_W'(pop_n) > level) ? level[2:0] : pop_n;
    idx = 3'd0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      lane_val[j] = 8'h00;
      if (3'(j) < pop_n) begin
        idx = pop_n - 3'd1 - 3'(j);
        if (idx < n_take)
          lane_val[j] = mem[rd_ptr + PTR_W'(idx)];
      end
    end
  end

  generate
    for (genvar j = 0; j < BUS_BYTES; j++) begin : g_pack
      assign packed_val[8*j +: 8] = lane_val[j];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push && !clr)
      mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      rdata  <= '0;
    end else begin
      if (pop_en)
        rdata <= packed_val;
      if (clr) begin
        rd_ptr <= wr_ptr;
        level  <= '0;
      end else begin
        wr_ptr <= wr_ptr + PTR_W'(push);
        rd_ptr <= rd_ptr + PTR_W'(n_take);
        level  <= level + LVL_W'(push) - LVL_W'(n_take);
      end
    end
  end
endmodule

// File: rtl/mmcf_xfer_ctrl.sv
module mmcf_xfer_ctrl #(
  parameter int BLKLEN_W = 12,
  parameter int NBLK_W   = 16,
  localparam int CNT_W   = BLKLEN_W + NBLK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                start_wr,
  input  logic [BLKLEN_W-1:0] blk_len,
  input  logic [NBLK_W-1:0]   blk_cnt,
  input  logic                moved,
  output logic                active,
  output logic                wr_mode,
  output logic                rem_nz,
  output logic                data_done,
  output logic                prog_done
);
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      active    <= 1'b0;
      wr_mode   <= 1'b0;
      data_done <= 1'b0;
      prog_done <= 1'b0;
    end else begin
      data_done <= 1'b0;
      prog_done <= 1'b0;
      if (start) begin
        remaining <= CNT_W'(blk_cnt) * CNT_W'(blk_len);
        active    <= 1'b1;
        wr_mode   <= start_wr;
      end else if (active) begin
        if (remaining == '0) begin
          active    <= 1'b0;
          data_done <= 1'b1;
          prog_done <= wr_mode;
        end else if (moved) begin
          remaining <= remaining - CNT_W'(1);
        end
      end
    end
  end

  assign rem_nz = (remaining != '0);
endmodule

// File: rtl/mmc_byte_fifo_pair.sv
module mmc_byte_fifo_pair
  import mmcf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int BLKLEN_W = 12,
  parameter int NBLK_W   = 16,
  localparam int LVL_W   = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xfer_start,
  input  logic                xfer_to_card,
  input  logic [BLKLEN_W-1:0] blk_len,
  input  logic [NBLK_W-1:0]   blk_cnt,
  input  logic                tx_wr_en,
  input  logic [1:0]          tx_size,
  input  logic [31:0]         tx_wdata,
  input  logic                part_flush,
  input  logic                rx_rd_en,
  input  logic [1:0]          rx_size,
  output logic [31:0]         rx_rdata,
  output logic [7:0]          tx_card_data,
  output logic                tx_card_valid,
  input  logic                tx_card_ready,
  input  logic [7:0]          rx_card_data,
  input  logic                rx_card_valid,
  output logic                rx_card_ready,
  output logic                tx_req,
  output logic                rx_req,
  output logic                data_done,
  output logic                prog_done,
  output logic                xfer_active
);
  logic             wr_mode, rem_nz;
  logic             tx_pop, rx_accept;
  logic [LVL_W-1:0] tx_level, rx_level;

  mmcf_xfer_ctrl #(.BLKLEN_W(BLKLEN_W), .NBLK_W(NBLK_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (xfer_start),
    .start_wr  (xfer_to_card),
    .blk_len   (blk_len),
    .blk_cnt   (blk_cnt),
    .moved     (tx_pop | rx_accept),
    .active    (xfer_active),
    .wr_mode   (wr_mode),
    .rem_nz    (rem_nz),
    .data_done (data_done),
    .prog_done (prog_done)
  );

  mmcf_tx_buf #(.DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .clr       (xfer_start),
    .flip      (part_flush),
    .push_en   (tx_wr_en),
    .push_n    (acc_bytes(tx_size)),
    .push_data (tx_wdata),
    .pop       (tx_pop),
    .head      (tx_card_data),
    .level     (tx_level)
  );

  mmcf_rx_buf #(.DEPTH(DEPTH)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .clr       (xfer_start),
    .push      (rx_accept),
    .push_byte (rx_card_data),
    .pop_en    (rx_rd_en),
    .pop_n     (acc_bytes(rx_size)),
    .rdata     (rx_rdata),
    .level     (rx_level)
  );

  assign tx_card_valid = xfer_active && wr_mode && rem_nz && (tx_level != '0);
  assign tx_pop        = tx_card_valid && tx_card_ready;
  assign rx_card_ready = xfer_active && !wr_mode && rem_nz && (rx_level < LVL_W'(DEPTH));
  assign rx_accept     = rx_card_ready && rx_card_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      if (tx_wr_en)
        tx_req <= 1'b0;
      else if (xfer_active && wr_mode && rem_nz)
        tx_req <= 1'b1;
      rx_req <= (rx_req && !rx_rd_en) || rx_accept;
    end
  end
endmodule

// File: rtl/mmcf_chk.sv
module mmcf_chk #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_card_valid,
  input logic             tx_card_ready,
  input logic [7:0]       tx_card_data,
  input logic             rx_card_valid,
  input logic             rx_card_ready,
  input logic             tx_wr_en,
  input logic             part_flush,
  input logic             xfer_start,
  input logic             tx_req,
  input logic             rx_req,
  input logic             data_done,
  input logic             prog_done,
  input logic             xfer_active,
  input logic             wr_mode,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level
);
  // R5
  tx_dir_chk: assert property (@(posedge clk) disable iff (rst)
    tx_card_valid |-> (xfer_active && wr_mode));
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_card_valid && !tx_card_ready && !part_flush && !xfer_start)
      |=> (tx_card_valid && $stable(tx_card_data)));
  // R4
  tx_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LVL_W'(DEPTH));
  // R11
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LVL_W'(DEPTH));
  // R6
  tx_req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tx_wr_en |=> !tx_req);
  // R7
  rx_req_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_req) |-> $past(rx_card_valid && rx_card_ready));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    data_done |=> !data_done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    data_done |-> !xfer_active);
  // R9
  prog_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> data_done);
endmodule

bind mmc_byte_fifo_pair mmcf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_card_valid (tx_card_valid),
  .tx_card_ready (tx_card_ready),
  .tx_card_data  (tx_card_data),
  .rx_card_valid (rx_card_valid),
  .rx_card_ready (rx_card_ready),
  .tx_wr_en      (tx_wr_en),
  .part_flush    (part_flush),
  .xfer_start    (xfer_start),
  .tx_req        (tx_req),
  .rx_req        (rx_req),
  .data_done     (data_done),
  .prog_done     (prog_done),
  .xfer_active   (xfer_active),
  .wr_mode       (wr_mode),
  .tx_level      (tx_level),
  .rx_level      (rx_level)
);

// File: tb/mmc_byte_fifo_pair_bench.sv
`timescale 1ns/1ps
module mmc_byte_fifo_pair_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_start = 1'b0, xfer_to_card = 1'b0;
  logic [11:0] blk_len = '0;
  logic [15:0] blk_cnt = '0;
  logic        tx_wr_en = 1'b0;
  logic [1:0]  tx_size = 2'd0;
  logic [31:0] tx_wdata = '0;
  logic        part_flush = 1'b0;
  logic        rx_rd_en = 1'b0;
  logic [1:0]  rx_size = 2'd0;
  logic [31:0] rx_rdata;
  logic [7:0]  tx_card_data;
  logic        tx_card_valid;
  logic        tx_card_ready = 1'b0;
  logic [7:0]  rx_card_data = '0;
  logic        rx_card_valid = 1'b0;
  logic        rx_card_ready;
  logic        tx_req, rx_req, data_done, prog_done, xfer_active;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxsrc[$];
  logic [7:0] rxexp[$];

  always #10 clk = ~clk;

  mmc_byte_fifo_pair u_mmc_byte_fifo_pair (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic start_xfer(input bit to_card, input int len, input int cnt);
    xfer_to_card = to_card; blk_len = 12'(len); blk_cnt = 16'(cnt);
    xfer_start = 1'b1; step(); xfer_start = 1'b0;
  endtask

  task automatic tx_write(input logic [1:0] sz, input logic [31:0] d);
    tx_wr_en = 1'b1; tx_size = sz; tx_wdata = d; step(); tx_wr_en = 1'b0;
  endtask

  task automatic rx_read(input logic [1:0] sz);
    rx_rd_en = 1'b1; rx_size = sz; step(); rx_rd_en = 1'b0;
  endtask

  task automatic wait_done(output bit prog);
    bit seen = 0;
    prog = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (data_done) begin seen = 1; prog = prog_done; end
    end
    chk("R9 data_done seen", 32'(seen), 32'd1);
    step();
  endtask

  // Scoreboard monitor for the byte stream toward the card
  always @(negedge clk) begin
    if (!rst && tx_card_valid && tx_card_ready) begin
      if (txq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4 unexpected byte actual=%h expected=none", tx_card_data);
      end else begin
        chk("R3 tx byte order", 32'(tx_card_data), 32'(txq.pop_front()));
      end
    end
  end

  // Card-side source for the receive stream
  initial forever begin
    @(posedge clk); #2;
    if (rxsrc.size() > 0) begin rx_card_valid = 1'b1; rx_card_data = rxsrc[0]; end
    else rx_card_valid = 1'b0;
    @(negedge clk);
    if (rx_card_valid && rx_card_ready) void'(rxsrc.pop_front());
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    bit pg;
    logic [31:0] w;
    repeat (4) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 tx_req", 32'(tx_req), 0);
    chk("R1 rx_req", 32'(rx_req), 0);
    chk("R1 active", 32'(xfer_active), 0);
    chk("R1 tx_card_valid", 32'(tx_card_valid), 0);
    chk("R1 rx_card_ready", 32'(rx_card_ready), 0);
    chk("R1 data_done", 32'(data_done), 0);

    // Write transfer: 4-byte then 2-byte access
    tx_card_ready = 1'b1;
    start_xfer(1, 6, 1);
    step();
    chk("R6 tx_req raised", 32'(tx_req), 1);
    txq.push_back(8'hA1); txq.push_back(8'hB2); txq.push_back(8'hC3); txq.push_back(8'hD4);
    tx_write(2'd2, 32'hA1B2C3D4);
    chk("R6 tx_req cleared by write", 32'(tx_req), 0);
    txq.push_back(8'hE5); txq.push_back(8'hF6);
    tx_write(2'd1, 32'h9999E5F6);
    wait_done(pg);
    chk("R9 prog_done in write", 32'(pg), 1);
    chk("R9 inactive", 32'(xfer_active), 0);
    chk("R3 all bytes sent", txq.size(), 0);

    // Fill to capacity, surplus dropped
    tx_card_ready = 1'b0;
    start_xfer(1, 36, 1);
    for (int i = 0; i < 8; i++) begin
      w = {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)};
      for (int b = 0; b < 4; b++) txq.push_back(8'(4*i+b));
      tx_write((i % 2 == 1) ? 2'd3 : 2'd2, w);
    end
    tx_write(2'd2, 32'hEEEEEEEE);
    tx_card_ready = 1'b1;
    repeat (40) step();
    chk("R4 32 bytes drained", txq.size(), 0);
    chk("R5 waits on empty buffer", 32'(xfer_active), 1);
    chk("R5 nothing offered when empty", 32'(tx_card_valid), 0);
    txq.push_back(8'h77);
    tx_write(2'd0, 32'hABCDEF77);
    txq.push_back(8'h11); txq.push_back(8'h22); txq.push_back(8'h33);
    tx_write(2'd2, 32'h11223344);
    wait_done(pg);
    chk("R9 prog_done after refill", 32'(pg), 1);
    chk("R4 tail bytes sent", txq.size(), 0);

    // Partial flush discards staged bytes
    tx_card_ready = 1'b0;
    start_xfer(1, 4, 1);
    tx_write(2'd2, 32'hDEADBEEF);
    part_flush = 1'b1; step(); part_flush = 1'b0;
    chk("R10 flushed buffer empty", 32'(tx_card_valid), 0);
    txq.push_back(8'h01); txq.push_back(8'h02); txq.push_back(8'h03); txq.push_back(8'h04);
    tx_write(2'd2, 32'h01020304);
    tx_card_ready = 1'b1;
    wait_done(pg);
    chk("R10 new half sent", txq.size(), 0);
    tx_card_ready = 1'b0;

    // Read transfer with packing into narrow widths
    rxsrc.push_back(8'h10); rxsrc.push_back(8'h20); rxsrc.push_back(8'h30);
    rxsrc.push_back(8'h40); rxsrc.push_back(8'h50);
    start_xfer(0, 5, 1);
    wait_done(pg);
    chk("R9 no prog_done in read", 32'(pg), 0);
    chk("R7 rx_req set", 32'(rx_req), 1);
    rx_read(2'd2);
    chk("R8 four-byte read", rx_rdata, 32'h10203040);
    chk("R7 rx_req cleared by read", 32'(rx_req), 0);
    rx_read(2'd1);
    chk("R8 short two-byte read", rx_rdata, 32'h00005000);
    rx_read(2'd0);
    chk("R8 empty read", rx_rdata, 32'h0);

    // Stream longer than the buffer: stall at full, then wrap
    for (int i = 0; i < 40; i++) begin
      rxsrc.push_back(8'(i*3+1));
      rxexp.push_back(8'(i*3+1));
    end
    start_xfer(0, 8, 5);
    repeat (45) step();
    chk("R7 stall when full", 32'(rx_card_ready), 0);
    chk("R2 count covers 40 bytes", 32'(xfer_active), 1);
    chk("R7 source held", rxsrc.size(), 8);
    for (int r = 0; r < 10; r++) begin
      rx_read(2'd2);
      w = {rxexp[0], rxexp[1], rxexp[2], rxexp[3]};
      repeat (4) void'(rxexp.pop_front());
      chk("R11 wrapped read", rx_rdata, w);
      repeat (6) step();
    end
    chk("R2 transfer finished", 32'(xfer_active), 0);

    // Zero-length transfer
    start_xfer(0, 12, 0);
    chk("R2 zero start active", 32'(xfer_active), 1);
    chk("R2 zero no early done", 32'(data_done), 0);
    step();
    chk("R2 zero done pulse", 32'(data_done), 1);
    chk("R9 zero read no prog", 32'(prog_done), 0);
    chk("R2 zero inactive", 32'(xfer_active), 0);

    finish_run();
  end
endmodule